// File: doc/BRIEF.md
# I2C Register-Access Target

This block is the bus-facing front end of a small peripheral whose registers are 8 bits wide. It watches the open-drain SCL and SDA pads and drives SDA low through a pull-low enable when it acknowledges or returns data. It recognises START, repeated START and STOP conditions. It answers to one of two 7-bit target addresses, and the address is chosen by a strap input.

A write transaction carries one register index and one data byte. The index stays in an internal pointer. A read transaction may first set the pointer with a write-direction register phase and a repeated START. A read may also go straight to the read-direction address, in which case it returns the register the pointer already selects. Each transaction moves exactly one data byte, and the pointer never advances on its own.

The block accesses the register file through a narrow port. That port has an address bus, a one-cycle write strobe with write data, and a one-cycle read strobe. Read data is sampled in the same cycle as the read strobe. Both pad inputs pass through a two-stage synchroniser and a run-length glitch filter sized from the system clock frequency. Every SDA change the block makes is delayed by a programmable hold time after SCL falls.

Top module: `i2c_reg_target`

## Requirements
- R1: The target address is 7'b1000011 when `addr_sel` is 0 and 7'b1000100 when it is 1. The address byte carries this address in bits 7:1 and the direction in bit 0 (0 = write, 1 = read). Any other address is not acknowledged, and the block then ignores the bus until the next START or STOP.
- R2: In a write, the block acknowledges the address byte, the register byte and the first data byte. It then issues exactly one `reg_we` pulse lasting one cycle, with `reg_addr` equal to the register byte and `reg_wdata` equal to the data byte.
- R3: In a read after a register phase and a repeated START, the block acknowledges the read address. It issues one `reg_re` pulse with `reg_addr` equal to the register byte, and it shifts the sampled `reg_rdata` out MSB first.
- R4: A read with no register phase returns the register at the current pointer. The pointer is the register byte of the most recent register phase, which may belong to a write, to an aborted transfer, or to a register phase closed by STOP. After reset the pointer is 0.
- R5: A second data byte in one write transaction is not acknowledged and causes no `reg_we`.
- R6: The block changes `sda_oe` no sooner than HOLD_NS after the filtered SCL falls, so SDA never moves while SCL is high. The only exceptions are releases caused by START or STOP.
- R7: A pulse on SCL or SDA shorter than GLITCH_NS is not taken as an edge, a START or a STOP.
- R8: A STOP at any point aborts the transfer and releases SDA. A STOP in the middle of a data byte causes no register write.
- R9: After reset, `sda_oe`, `reg_we` and `reg_re` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that selects one of the two target addresses |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_oe | output | 1 | Pull-low enable for the SDA pad |
| reg_addr | output | 8 | Register pointer, presented to the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Data for the register write |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register read data, sampled while `reg_re` is high |

## Verification
Four properties are checked on every cycle:
- every SDA change waits for the hold time after the filtered SCL fall, unless a START or STOP caused the release;
- a STOP always leaves SDA released;
- write strobes last one cycle;
- write and read strobes never coincide.

Other behaviour only shows up in the bench's scenarios: address matching for both strap values, pointer retention across plain reads, rejection of a second write byte, aborts caused by STOP, and immunity to short pulses on both pads. The bench shows each of these through the acknowledge bits, the returned data and the register file.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_HOST_ACK,
    ST_SKIP
  } tgt_state_e;

  // Round a duration in ns up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Target address selected by the strap.
  function automatic logic [6:0] own_addr(logic strap);
    return strap ? 7'b1000100 : 7'b1000011;
  endfunction

  function automatic logic addr_hit(logic [7:0] b, logic strap);
    return b[7:1] == own_addr(strap);
  endfunction

endpackage

// File: rtl/i2c_tgt_filt.sv
module i2c_tgt_filt #(
  parameter int unsigned RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(RUN + 1);

  logic          s1, s2;
  logic [CW-1:0] run_cnt;

  // Two-stage synchroniser, then the output follows only a level that
  // differs from it for RUN consecutive cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      line_o  <= 1'b1;
      run_cnt <= '0;
    end else begin
      s1 <= pad_i;
      s2 <= s1;
      if (s2 == line_o) begin
        run_cnt <= '0;
      end else if (run_cnt == CW'(RUN - 1)) begin
        line_o  <= s2;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  tgt_state_e    state;
  logic [3:0]    bcnt;
  logic [7:0]    shreg, tx, ptr;
  logic          rd_dir, wdone, hpend;
  logic [HW-1:0] hcnt;
  logic          sda_want;
  logic          byte_done;

  assign byte_done = scl_fall && (bcnt == 4'd8);
  assign reg_addr  = ptr;

  always_comb begin
    unique case (state)
      ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: sda_want = 1'b1;
      ST_RDAT:                             sda_want = ~tx[7];
      default:                             sda_want = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      shreg     <= '0;
      tx        <= '0;
      ptr       <= '0;
      rd_dir    <= 1'b0;
      wdone     <= 1'b0;
      hpend     <= 1'b0;
      hcnt      <= '0;
      sda_oe    <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= '0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_re) tx <= reg_rdata;
      if (start_evt) begin
        state  <= ST_DEV;
        bcnt   <= '0;
        wdone  <= 1'b0;
        hpend  <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= ST_IDLE;
        hpend  <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise) begin
          unique case (state)
            ST_DEV, ST_REG, ST_WDAT: begin
              shreg <= {shreg[6:0], sda_f};
              bcnt  <= bcnt + 1'b1;
            end
            ST_RDAT: bcnt <= bcnt + 1'b1;
            default: ;
          endcase
        end
        if (scl_fall) begin
          hpend <= 1'b1;
          hcnt  <= HW'(HOLD_CYC - 1);
          unique case (state)
            ST_DEV: if (byte_done) begin
              bcnt <= '0;
              if (addr_hit(shreg, addr_sel)) begin
                state  <= ST_DEV_ACK;
                rd_dir <= shreg[0];
                reg_re <= shreg[0];
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_DEV_ACK: begin
              state <= rd_dir ? ST_RDAT : ST_REG;
              bcnt  <= '0;
            end
            ST_REG: if (byte_done) begin
              ptr   <= shreg;
              state <= ST_REG_ACK;
            end
            ST_REG_ACK: begin
              state <= ST_WDAT;
              bcnt  <= '0;
            end
            ST_WDAT: if (byte_done) begin
              if (!wdone) begin
                reg_we    <= 1'b1;
                reg_wdata <= shreg;
                wdone     <= 1'b1;
                state     <= ST_WDAT_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_WDAT_ACK: begin
              state <= ST_WDAT;
              bcnt  <= '0;
            end
            ST_RDAT: begin
              if (bcnt == 4'd8) state <= ST_HOST_ACK;
              else              tx    <= {tx[6:0], 1'b0};
            end
            ST_HOST_ACK: state <= ST_SKIP;
            default: ;
          endcase
        end else if (hpend) begin
          if (hcnt == '0) begin
            hpend  <= 1'b0;
            sda_oe <= sda_want;
          end else begin
            hcnt <= hcnt - 1'b1;
          end
        end
      end
    end
  end

  // Checker state: cycles since the last filtered SCL fall, saturating.
  logic [HW:0] since_fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             since_fall <= '0;
    else if (scl_fall)                      since_fall <= '0;
    else if (since_fall != {(HW + 1){1'b1}}) since_fall <= since_fall + 1'b1;
  end

  // R6
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(sda_oe) && !$past(start_evt) && !$past(stop_evt))
      |-> (since_fall >= (HW + 1)'(HOLD_CYC) && !scl_f));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R2
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned GLITCH_NS = 50,
  parameter int unsigned HOLD_NS   = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  output logic       reg_re,
  input  logic [7:0] reg_rdata
);
  localparam int unsigned FILT_RUN = ns_to_cyc(GLITCH_NS, CLK_MHZ) + 1;
  localparam int unsigned HOLD_CYC = ns_to_cyc(HOLD_NS, CLK_MHZ);

  logic [1:0] pad_raw, pad_f;
  logic       scl_rise, scl_fall, start_evt, stop_evt;

  assign pad_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_tgt_filt #(.RUN(FILT_RUN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_i  (pad_raw[g]),
      .line_o (pad_f[g])
    );
  end

  i2c_tgt_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (pad_f[0]),
    .sda_f     (pad_f[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_tgt_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_sel  (addr_sel),
    .scl_f     (pad_f[0]),
    .sda_f     (pad_f[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_re    (reg_re),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int Q = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1, scl_g = 1'b0, sda_g = 1'b0;
  logic scl_line, sda_line;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  int we_cnt = 0, re_cnt = 0;
  logic [7:0] last_re_addr = 8'h00;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign scl_line  = scl_d | scl_g;
  assign sda_line  = sda_d & ~sda_oe & ~sda_g;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target u_dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(strap),
    .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  initial begin
    for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (reg_re) begin
      re_cnt <= re_cnt + 1;
      last_re_addr <= reg_addr;
    end
  end

  function automatic logic [6:0] tgt_of(logic s);
    return s ? 7'h44 : 7'h43;
  endfunction

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start;
    sda_d = 1'b1; wq(Q); scl_d = 1'b1; wq(Q);
    sda_d = 1'b0; wq(Q); scl_d = 1'b0; wq(Q);
  endtask

  task automatic do_stop;
    sda_d = 1'b0; wq(Q); scl_d = 1'b1; wq(Q); sda_d = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b, input logic gl);
    sda_d = b;
    if (gl) begin
      wq(Q / 2); scl_g = 1'b1; wq(3); scl_g = 1'b0; wq(Q - Q / 2 - 3);
    end else wq(Q);
    scl_d = 1'b1;
    if (gl && b) begin
      wq(Q / 2); sda_g = 1'b1; wq(3); sda_g = 1'b0; wq(Q - Q / 2 - 3);
    end else wq(Q);
    wq(Q);
    scl_d = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_d = 1'b1; wq(Q); scl_d = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_d = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic gl, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], gl);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(1'b1, 1'b0);
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                        input logic gl, output logic [2:0] acks);
    do_start;
    send_byte({a, 1'b0}, gl, acks[2]);
    send_byte(r, gl, acks[1]);
    send_byte(d, gl, acks[0]);
    do_stop;
  endtask

  task automatic rd_txn(input logic [6:0] a, input logic use_reg, input logic [7:0] r,
                        output logic [7:0] d, output logic [1:0] acks);
    logic t;
    acks = 2'b11;
    if (use_reg) begin
      do_start;
      send_byte({a, 1'b0}, 1'b0, t);
      acks[1] = t;
      send_byte(r, 1'b0, t);
      acks[1] = acks[1] & t;
    end
    do_start;
    send_byte({a, 1'b1}, 1'b0, acks[0]);
    recv_byte(d);
    do_stop;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] wa;
    logic [1:0] ra;
    logic [7:0] rd, r, d, exp_d;
    logic t;
    int w0, r0;
    int unsigned seed = 32'd2718;
    void'($urandom(seed));

    wq(4);
    // R9 reset state
    check("R9 sda_oe", int'(sda_oe), 0);
    check("R9 reg_we", int'(reg_we), 0);
    check("R9 reg_re", int'(reg_re), 0);
    rst_n = 1'b1;
    wq(10);

    // R2 directed write
    w0 = we_cnt;
    wr_txn(tgt_of(1'b0), 8'h05, 8'hA5, 1'b0, wa);
    check("R2 acks", int'(wa), 7);
    check("R2 one write", we_cnt - w0, 1);
    check("R2 data", int'(mem[8'h05]), 8'hA5);

    // R3 read with register phase
    r0 = re_cnt;
    rd_txn(tgt_of(1'b0), 1'b1, 8'h05, rd, ra);
    check("R3 acks", int'(ra), 3);
    check("R3 data", int'(rd), 8'hA5);
    check("R3 one strobe", re_cnt - r0, 1);
    check("R3 strobe addr", int'(last_re_addr), 8'h05);

    // R4 pointer set by a register phase closed by STOP, then a plain read
    do_start;
    send_byte({tgt_of(1'b0), 1'b0}, 1'b0, t);
    send_byte(8'h20, 1'b0, t);
    do_stop;
    rd_txn(tgt_of(1'b0), 1'b0, 8'h00, rd, ra);
    check("R4 plain read", int'(rd), int'(8'h20 ^ 8'h5A));
    check("R4 ack", int'(ra[0]), 1);

    // R1 mismatch with strap low
    w0 = we_cnt;
    do_start;
    send_byte({tgt_of(1'b1), 1'b0}, 1'b0, t);
    check("R1 nack strap0", int'(t), 0);
    send_byte(8'h05, 1'b0, t);
    check("R1 ignored byte nack", int'(t), 0);
    do_stop;
    check("R1 no write", we_cnt - w0, 0);

    // R1 strap high
    strap = 1'b1;
    wq(10);
    wr_txn(tgt_of(1'b1), 8'h11, 8'h3C, 1'b0, wa);
    check("R1 ack strap1", int'(wa), 7);
    check("R1 data strap1", int'(mem[8'h11]), 8'h3C);
    do_start;
    send_byte({tgt_of(1'b0), 1'b1}, 1'b0, t);
    check("R1 nack strap1", int'(t), 0);
    do_stop;
    strap = 1'b0;
    wq(10);

    // R5 second data byte rejected
    w0 = we_cnt;
    do_start;
    send_byte({tgt_of(1'b0), 1'b0}, 1'b0, t);
    send_byte(8'h40, 1'b0, t);
    send_byte(8'h12, 1'b0, t);
    check("R5 first ack", int'(t), 1);
    send_byte(8'h34, 1'b0, t);
    check("R5 second nack", int'(t), 0);
    do_stop;
    check("R5 one write", we_cnt - w0, 1);
    rd_txn(tgt_of(1'b0), 1'b0, 8'h00, rd, ra);
    check("R5 keeps first", int'(rd), 8'h12);

    // R8 STOP inside a data byte
    w0 = we_cnt;
    do_start;
    send_byte({tgt_of(1'b0), 1'b0}, 1'b0, t);
    send_byte(8'h30, 1'b0, t);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    do_stop;
    check("R8 no write", we_cnt - w0, 0);
    check("R8 released", int'(sda_oe), 0);
    rd_txn(tgt_of(1'b0), 1'b0, 8'h00, rd, ra);
    check("R8 reg intact", int'(rd), int'(8'h30 ^ 8'h5A));

    // R7 glitches on both lines during a write
    wr_txn(tgt_of(1'b0), 8'h6B, 8'hD9, 1'b1, wa);
    check("R7 acks", int'(wa), 7);
    check("R7 data", int'(mem[8'h6B]), 8'hD9);
    rd_txn(tgt_of(1'b0), 1'b0, 8'h00, rd, ra);
    check("R7 readback", int'(rd), 8'hD9);

    // R2/R3 random write then read-back
    for (int k = 0; k < 3; k++) begin
      r = 8'($urandom);
      d = 8'($urandom);
      wr_txn(tgt_of(1'b0), r, d, 1'b0, wa);
      check("R2 rand acks", int'(wa), 7);
      exp_d = d;
      rd_txn(tgt_of(1'b0), 1'b1, r, rd, ra);
      check("R3 rand data", int'(rd), int'(exp_d));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule